// File: doc/BRIEF.md
# UART Receive Queue with Trigger-Level Interrupt

This block sits between the receive deserializer of a UART and the host-visible receive buffer register. Each byte that the deserializer finishes is offered on a write strobe and stored in a small first-in first-out queue. The host removes bytes through a read strobe. A data-available interrupt is raised once the number of stored bytes reaches a level picked by a two-bit select, so that the host can service several bytes per interrupt instead of one.

When queueing is switched off, the block falls back to a single holding register in the style of the earliest UART parts. A new byte then replaces an unread one and flags an overrun. A one-cycle clear pulse empties the queue without touching anything upstream. The block also registers the receiver line-status interrupt enable bit and passes it on to the error logic, which lives elsewhere.

All outputs come from registers, or from registers through a multiplexer. Each output shows the state left by the most recent rising clock edge, taking into account the strobes sampled at that edge.

Top module: `uart_rxq`

## Requirements
- R1: While `rst` is high at a rising edge, the queue and holding register empty, and `fill_count`, `data_ready`, `overrun`, `rda_irq`, `rls_irq_en` and `rbr_word` all go to zero.
- R2: With `fifo_en`=1, accepted bytes leave in arrival order, up to DEPTH (16) bytes. `fill_count` gives the number held, `data_ready` is 1 when that number is non-zero, and `head_byte` shows the oldest byte.
- R3: `rda_irq` is 1 after an edge exactly when `ie_bits[0]` was 1 and the count after that edge is at least the selected level. With `fifo_en`=1, `trig_sel` 2'b00 gives 1, 2'b01 gives DEPTH/4 (4), 2'b10 gives DEPTH/2 (8) and 2'b11 gives DEPTH (16).
- R4: A write while the queue is full and no byte leaves in the same cycle drops the new byte and sets `overrun`. `overrun` stays set until a clear, a mode change or reset. A read in the same cycle makes room, so the write is accepted.
- R5: `fifo_clr`=1 empties the queue and holding register and clears `overrun`. It wins over a write or read in the same cycle, and it leaves `rbr_word` unchanged.
- R6: A read while nothing is held changes neither `fill_count` nor `rbr_word`.
- R7: With `fifo_en`=0, the block holds at most one byte (`fill_count` 0 or 1). A write while that byte is unread replaces it with the new byte and sets `overrun`. The interrupt level is one byte.
- R8: A cycle in which `fifo_en` differs from its value at the previous edge flushes all stored bytes and clears `overrun`. A write in that cycle is dropped.
- R9: `rbr_word` bits 31:8 read as zero. Bits 7:0 take the byte removed by the most recent accepted read.
- R10: `rls_irq_en` follows `ie_bits[2]` one edge later. `ie_bits[1]` affects no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Deserializer has a finished byte |
| wr_byte | input | DATA_W (8) | Byte from the deserializer |
| rd_stb | input | 1 | Host reads the receive buffer register |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| fifo_clr | input | 1 | One-cycle queue clear pulse |
| trig_sel | input | 2 | Interrupt level select |
| ie_bits | input | 3 | Interrupt enables: bit 0 data available, bit 2 line status |
| head_byte | output | DATA_W (8) | Oldest stored byte, valid while data_ready |
| rbr_word | output | BUS_W (32) | Receive buffer register read value |
| data_ready | output | 1 | At least one byte is held |
| fill_count | output | CNT_W (5) | Number of bytes held |
| overrun | output | 1 | Sticky lost-byte flag |
| rda_irq | output | 1 | Data-available interrupt request |
| rls_irq_en | output | 1 | Registered line-status interrupt enable |

## Verification
The bench builds the block with its default parameters: DATA_W 8, BUS_W 32 and DEPTH 16. At depth 16 the four interrupt levels 1, 4, 8 and 16 are distinct, so each threshold crossing can be observed. A full queue is only sixteen writes away, which lets random traffic reach overrun, read-while-full and clear-while-full often. Random switching of `fifo_en` then exercises the holding-register mode and the flush on a mode change alongside the directed cases.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Interrupt threshold for a two-bit select, scaled to the queue depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_nxt
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  // Storage array: no reset, single write port, so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign head = mem[rd_ptr];

  always_comb begin
    cnt_nxt = cnt;
    if (flush) begin
      cnt_nxt = '0;
    end else begin
      case ({push, pop})
        2'b10:   cnt_nxt = cnt + CNT_W'(1);
        2'b01:   cnt_nxt = cnt - CNT_W'(1);
        default: cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/uart_rxq_hold.sv
module uart_rxq_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              full_nxt
);
  always_comb begin
    if (flush)     full_nxt = 1'b0;
    else if (load) full_nxt = 1'b1;
    else if (pop)  full_nxt = 1'b0;
    else           full_nxt = full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_nxt;
      if (load) data <= din;
    end
  end

endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] q_cnt_nxt,
  input  logic             h_full_nxt,
  input  logic [1:0]       trig_sel,
  input  logic             rda_en,
  input  logic             rls_en,
  output logic             rda_irq,
  output logic             rls_irq_en
);
  import uart_rxq_pkg::*;

  logic [CNT_W-1:0] level;
  logic             reached;

  assign level   = CNT_W'(trig_level(trig_sel, DEPTH));
  assign reached = fifo_mode ? (q_cnt_nxt >= level) : h_full_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rda_irq    <= 1'b0;
      rls_irq_en <= 1'b0;
    end else begin
      rda_irq    <= rda_en && reached;
      rls_irq_en <= rls_en;
    end
  end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_stb,
  input  logic              fifo_en,
  input  logic              fifo_clr,
  input  logic [1:0]        trig_sel,
  input  logic [2:0]        ie_bits,
  output logic [DATA_W-1:0] head_byte,
  output logic [BUS_W-1:0]  rbr_word,
  output logic              data_ready,
  output logic [CNT_W-1:0]  fill_count,
  output logic              overrun,
  output logic              rda_irq,
  output logic              rls_irq_en
);
  logic              mode_q;
  logic              flush;
  logic              q_push, q_pop;
  logic              h_load, h_pop;
  logic [DATA_W-1:0] q_head, h_data;
  logic [CNT_W-1:0]  q_cnt, q_cnt_nxt;
  logic              h_full, h_full_nxt;
  logic              ovr_set;
  logic [DATA_W-1:0] rbr_q;

  // A mode change flushes, just like the clear pulse.
  assign flush = fifo_clr || (fifo_en != mode_q);

  assign q_pop  = fifo_en && rd_stb && (q_cnt != '0) && !flush;
  assign q_push = fifo_en && wr_stb && !flush &&
                  ((q_cnt != CNT_W'(DEPTH)) || q_pop);
  assign h_pop  = !fifo_en && rd_stb && h_full && !flush;
  assign h_load = !fifo_en && wr_stb && !flush;

  assign ovr_set = wr_stb && !flush &&
                   (fifo_en ? !q_push : (h_full && !h_pop));

  uart_rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(q_push), .pop(q_pop),
    .din(wr_byte), .head(q_head), .cnt(q_cnt), .cnt_nxt(q_cnt_nxt)
  );

  uart_rxq_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .flush(flush), .load(h_load), .pop(h_pop),
    .din(wr_byte), .data(h_data), .full(h_full), .full_nxt(h_full_nxt)
  );

  uart_rxq_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .fifo_mode(fifo_en), .q_cnt_nxt(q_cnt_nxt),
    .h_full_nxt(h_full_nxt), .trig_sel(trig_sel), .rda_en(ie_bits[0]),
    .rls_en(ie_bits[2]), .rda_irq(rda_irq), .rls_irq_en(rls_irq_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= fifo_en;
      overrun <= 1'b0;
      rbr_q   <= '0;
    end else begin
      mode_q <= fifo_en;
      if (flush)        overrun <= 1'b0;
      else if (ovr_set) overrun <= 1'b1;
      if (q_pop)      rbr_q <= q_head;
      else if (h_pop) rbr_q <= h_data;
    end
  end

  assign head_byte  = mode_q ? q_head : h_data;
  assign fill_count = mode_q ? q_cnt : CNT_W'(h_full);
  assign data_ready = (fill_count != '0);
  assign rbr_word   = {{(BUS_W-DATA_W){1'b0}}, rbr_q};

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             fifo_en,
  input logic             fifo_clr,
  input logic [2:0]       ie_bits,
  input logic [BUS_W-1:0] rbr_word,
  input logic             data_ready,
  input logic [CNT_W-1:0] fill_count,
  input logic             overrun,
  input logic             rda_irq,
  input logic             rls_irq_en
);
  logic en_prev;
  always_ff @(posedge clk) en_prev <= fifo_en;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CNT_W'(DEPTH));

  p_ready_match_r2: assert property (@(posedge clk) disable iff (rst)
    data_ready == (fill_count != '0));

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !ie_bits[0] |=> !rda_irq);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && en_prev && !fifo_clr && wr_stb && !rd_stb &&
     fill_count == CNT_W'(DEPTH)) |=> (overrun && fill_count == CNT_W'(DEPTH)));

  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (overrun && !fifo_clr && fifo_en == en_prev) |=> overrun);

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (fill_count == '0 && !overrun));

  p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !data_ready) |=> $stable(rbr_word));

  p_single_depth_r7: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> fill_count <= CNT_W'(1));

  p_mode_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != en_prev) |=> (fill_count == '0 && !overrun));

  p_rls_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rls_irq_en == $past(ie_bits[2]));

endmodule

bind uart_rxq uart_rxq_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .fifo_en(fifo_en),
  .fifo_clr(fifo_clr), .ie_bits(ie_bits), .rbr_word(rbr_word),
  .data_ready(data_ready), .fill_count(fill_count), .overrun(overrun),
  .rda_irq(rda_irq), .rls_irq_en(rls_irq_en)
);

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_stb = 1'b0;
  logic [7:0]       wr_byte = '0;
  logic             rd_stb = 1'b0;
  logic             fifo_en = 1'b1;
  logic             fifo_clr = 1'b0;
  logic [1:0]       trig_sel = 2'b00;
  logic [2:0]       ie_bits = 3'b000;
  logic [7:0]       head_byte;
  logic [31:0]      rbr_word;
  logic             data_ready;
  logic [CNT_W-1:0] fill_count;
  logic             overrun;
  logic             rda_irq;
  logic             rls_irq_en;

  always #10 clk = ~clk;

  uart_rxq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb),
    .fifo_en(fifo_en), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
    .ie_bits(ie_bits), .head_byte(head_byte), .rbr_word(rbr_word),
    .data_ready(data_ready), .fill_count(fill_count), .overrun(overrun),
    .rda_irq(rda_irq), .rls_irq_en(rls_irq_en)
  );

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 0;

  // Reference state
  logic [7:0] mq[$];
  logic [7:0] m_rbr = '0;
  logic       m_ovr = 0;
  logic       m_irq = 0;
  logic       m_rls = 0;
  logic       m_en_prev = 1;

  function automatic int level_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act,
                       input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check("fill_count", 32'(fill_count), 32'(mq.size()), tag);
    check("data_ready", 32'(data_ready), 32'(mq.size() != 0), tag);
    if (mq.size() != 0) check("head_byte", 32'(head_byte), 32'(mq[0]), tag);
    check("rbr_word", rbr_word, {24'h0, m_rbr}, tag);
    check("overrun", 32'(overrun), 32'(m_ovr), tag);
    check("rda_irq", 32'(rda_irq), 32'(m_irq), tag);
    check("rls_irq_en", 32'(rls_irq_en), 32'(m_rls), tag);
  endtask

  task automatic model_edge(input logic w, input logic [7:0] d,
                            input logic r, input logic c);
    logic flush;
    flush = c || (fifo_en != m_en_prev);
    m_en_prev = fifo_en;
    if (flush) begin
      mq.delete();
      m_ovr = 0;
    end else if (fifo_en) begin
      if (r && mq.size() > 0) m_rbr = mq.pop_front();
      if (w) begin
        if (mq.size() < DEPTH) mq.push_back(d);
        else m_ovr = 1;
      end
    end else begin
      if (r && mq.size() > 0) m_rbr = mq.pop_front();
      if (w) begin
        if (mq.size() == 1) begin
          m_ovr = 1;
          mq[0] = d;
        end else begin
          mq.push_back(d);
        end
      end
    end
    m_irq = ie_bits[0] && (fifo_en ? (mq.size() >= level_of(trig_sel))
                                   : (mq.size() == 1));
    m_rls = ie_bits[2];
  endtask

  // Called at a falling edge; ends at the next falling edge after comparing.
  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic c, input string tag);
    wr_stb = w; wr_byte = d; rd_stb = r; fifo_clr = c;
    @(posedge clk);
    model_edge(w, d, r, c);
    @(negedge clk);
    compare_all(tag);
    wr_stb = 0; rd_stb = 0; fifo_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    // R1: reset values
    ie_bits = 3'b111;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst = 0;
    m_en_prev = fifo_en;

    // R2 / R3: fill with level 4, watch threshold crossing
    trig_sel = 2'b01; ie_bits = 3'b001;
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0, "R3");
    trig_sel = 2'b10;
    step(0, 8'h00, 0, 0, "R3");
    for (int i = 5; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0, "R2");
    trig_sel = 2'b11;
    step(0, 8'h00, 0, 0, "R3");

    // R4: write to full queue, then write with read
    step(1, 8'hEE, 0, 0, "R4");
    step(1, 8'hA5, 1, 0, "R4");
    step(0, 8'h00, 0, 0, "R4");

    // R2 / R9: drain in order
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 1, 0, "R9");
    // R6: read while empty
    step(0, 8'h00, 1, 0, "R6");
    step(0, 8'h00, 1, 0, "R6");

    // R5: clear with data, clear beating a write
    for (int i = 0; i < 3; i++) step(1, 8'hC0 + 8'(i), 0, 0, "R5");
    step(1, 8'h77, 1, 1, "R5");
    step(0, 8'h00, 0, 0, "R5");

    // R8: mode change flushes stored bytes
    step(1, 8'h31, 0, 0, "R8");
    step(1, 8'h32, 0, 0, "R8");
    fifo_en = 0;
    step(1, 8'h33, 0, 0, "R8");

    // R7: single holding register, overwrite sets overrun
    step(1, 8'h41, 0, 0, "R7");
    step(1, 8'h42, 0, 0, "R7");
    step(1, 8'h43, 1, 0, "R7");
    step(0, 8'h00, 1, 0, "R7");
    step(0, 8'h00, 1, 0, "R7");
    fifo_en = 1;
    step(0, 8'h00, 0, 0, "R8");

    // R10: bit 1 alone changes nothing, bit 2 passes through
    ie_bits = 3'b010;
    step(1, 8'hFF, 0, 0, "R10");
    ie_bits = 3'b100;
    step(0, 8'h00, 1, 0, "R10");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic w, r, c;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 40;
      c = ($urandom % 100) < 2;
      if (($urandom % 100) < 5) trig_sel = 2'($urandom);
      if (($urandom % 100) < 5) ie_bits = 3'($urandom);
      if (($urandom % 1000) < 8) fifo_en = ~fifo_en;
      step(w, 8'($urandom), r, c, "R2");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule